// File: doc/BRIEF.md
# Buffer-to-Buffer Transfer Sequencer

The sequencer is a small, non-pipelined controller that copies words from the output buffer of one processing stage into the input buffer of the next stage. It runs a short program of 32-bit instructions. The program is read from a local instruction memory through a combinational fetch port. Four operations are enough for a statically scheduled transfer: a wait of a set number of cycles, a register load, a single move, and a strided burst move. The waits let a compiler place every transfer on the exact clock cycle that the schedule calls for.

A one-cycle start pulse points the program counter at address 0 and begins execution. A program normally ends with a zero-length wait. This parks the sequencer until the next start pulse. Reads from the output buffer return data one clock after the request. The sequencer forwards that data to the input-buffer write port in the same cycle it arrives, so each write follows its read by exactly one cycle.

Top module: `xfer_seq`

## Requirements
- R1: After reset, `busy_o` is low, no read or write is requested, the program counter is 0, and all registers read as zero.
- R2: Instruction fields are: opcode in bits [31:28], rd in [27:24], rs1 in [23:20], rs2 in [19:16], and a 16-bit immediate in [15:0]. The opcodes are wait=0000, load=0010, move=1000 and burst=1001. A start pulse sampled on a clock edge makes the next cycle execute the word at address 0, with `busy_o` high. `imem_addr_o` shows the address of the instruction being executed.
- R3: The load instruction writes the immediate into the register selected by rd and takes one cycle. A load to register 0 is discarded, and register 0 always reads as zero.
- R4: A wait with a nonzero immediate n takes exactly n cycles before the next instruction is fetched, with no buffer traffic.
- R5: A wait with an immediate of zero halts execution. From the next cycle on, `busy_o` is low, no reads or writes occur, and the program counter holds until a start pulse arrives.
- R6: The move instruction reads the output buffer at reg[rs1]+imm. One cycle later it writes the returned data to the input buffer at reg[rd]+imm. It takes two cycles.
- R7: The burst instruction with count n>0 (the immediate) issues n reads on consecutive cycles at reg[rs1]+k*reg[rs2] for k = 0 to n-1. Each read is followed one cycle later by a write at reg[rd]+k*reg[rs2]. It takes n+1 cycles. With n=0 it takes one cycle and moves nothing.
- R8: Any other opcode executes as a one-cycle wait.
- R9: A start pulse during a running program abandons it and restarts at address 0.
- R10: All address sums wrap modulo 2^16.
- R11: At most one read is issued per cycle, and a write occurs in a cycle if and only if a read was issued in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start pulse; restarts execution at address 0 |
| imem_addr_o | output | $clog2(IMEM_DEPTH) | Instruction fetch address (program counter) |
| imem_data_i | input | 32 | Instruction word at `imem_addr_o`, combinational |
| ob_rd_en_o | output | 1 | Output-buffer read request |
| ob_addr_o | output | 16 | Output-buffer read address |
| ob_data_i | input | DATA_W | Output-buffer read data, valid one cycle after the request |
| ib_wr_en_o | output | 1 | Input-buffer write enable |
| ib_addr_o | output | 16 | Input-buffer write address |
| ib_data_o | output | DATA_W | Input-buffer write data |
| busy_o | output | 1 | High while a program is executing |

## Verification
The assertions assume the following about the inputs:
- `start_i` is a synchronous signal that is stable around each rising edge.
- The instruction word is valid combinationally for the address on the fetch port.
- The output buffer answers every request on the following cycle.

The bench models the instruction memory as a direct array lookup and the output buffer as a register that is loaded on each request. It changes `start_i` only at falling edges. It restarts a program only while that program sits in a timed wait, so no half-finished move is ever abandoned. Random programs keep wait and burst lengths small, so every run stays well inside the bench's cycle-by-cycle expectation tables.

// File: rtl/xs_pkg.sv
package xs_pkg;
  localparam int INSN_W = 32;
  localparam int IMM_W  = 16;
  localparam int NREG   = 16;
  localparam int RIDX_W = $clog2(NREG);

  typedef enum logic [3:0] {
    OP_WAIT  = 4'b0000,
    OP_LOAD  = 4'b0010,
    OP_MOVE  = 4'b1000,
    OP_BURST = 4'b1001
  } op_e;

  typedef struct packed {
    logic [3:0]        op;
    logic [RIDX_W-1:0] rd;
    logic [RIDX_W-1:0] rs1;
    logic [RIDX_W-1:0] rs2;
    logic [IMM_W-1:0]  imm;
  } insn_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EXEC,
    ST_WAIT,
    ST_BURST,
    ST_DRAIN
  } st_e;
endpackage

// File: rtl/xs_regfile.sv
module xs_regfile #(
  parameter  int W  = 16,
  parameter  int N  = 16,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [IW-1:0] ra_a_i,
  input  logic [IW-1:0] ra_b_i,
  input  logic [IW-1:0] ra_c_i,
  output logic [W-1:0]  rd_a_o,
  output logic [W-1:0]  rd_b_o,
  output logic [W-1:0]  rd_c_o
);
  logic [W-1:0] regs_q [N];
  logic [N-1:0] row_we;

  // Per-row write enables; row 0 never enabled so it stays zero.
  generate
    for (genvar g = 0; g < N; g++) begin : g_we
      if (g == 0) begin : g_zero
        assign row_we[g] = 1'b0;
      end else begin : g_row
        assign row_we[g] = we_i && (waddr_i == IW'(g));
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (row_we[i]) regs_q[i] <= wdata_i;
      end
    end
  end

  assign rd_a_o = regs_q[ra_a_i];
  assign rd_b_o = regs_q[ra_b_i];
  assign rd_c_o = regs_q[ra_c_i];
endmodule

// File: rtl/xs_ctrl.sv
module xs_ctrl
  import xs_pkg::*;
#(
  parameter int PC_W  = 6,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [3:0]       op_i,
  input  logic [CNT_W-1:0] imm_i,
  output logic [PC_W-1:0]  pc_o,
  output logic             busy_o,
  output logic             ld_we_o,
  output logic             issue_first_o,
  output logic             issue_next_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [PC_W-1:0]  PC_ONE  = PC_W'(1);

  st_e              st_q, st_d;
  logic [PC_W-1:0]  pc_q, pc_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pc_en, cnt_en;

  always_comb begin
    st_d          = st_q;
    pc_d          = pc_q;
    cnt_d         = cnt_q;
    ld_we_o       = 1'b0;
    issue_first_o = 1'b0;
    issue_next_o  = 1'b0;
    if (start_i) begin
      st_d = ST_EXEC;
      pc_d = '0;
    end else begin
      case (st_q)
        ST_EXEC: begin
          case (op_e'(op_i))
            OP_WAIT: begin
              if (imm_i == '0) begin
                st_d = ST_IDLE;
              end else if (imm_i == CNT_ONE) begin
                pc_d = pc_q + PC_ONE;
              end else begin
                cnt_d = imm_i - CNT_ONE;
                st_d  = ST_WAIT;
              end
            end
            OP_LOAD: begin
              ld_we_o = 1'b1;
              pc_d    = pc_q + PC_ONE;
            end
            OP_MOVE: begin
              issue_first_o = 1'b1;
              st_d          = ST_DRAIN;
            end
            OP_BURST: begin
              if (imm_i == '0) begin
                pc_d = pc_q + PC_ONE;
              end else begin
                issue_first_o = 1'b1;
                cnt_d         = imm_i - CNT_ONE;
                st_d          = (imm_i == CNT_ONE) ? ST_DRAIN : ST_BURST;
              end
            end
            default: pc_d = pc_q + PC_ONE;
          endcase
        end
        ST_WAIT: begin
          if (cnt_q == CNT_ONE) begin
            st_d = ST_EXEC;
            pc_d = pc_q + PC_ONE;
          end else begin
            cnt_d = cnt_q - CNT_ONE;
          end
        end
        ST_BURST: begin
          issue_next_o = 1'b1;
          cnt_d        = cnt_q - CNT_ONE;
          if (cnt_q == CNT_ONE) st_d = ST_DRAIN;
        end
        ST_DRAIN: begin
          st_d = ST_EXEC;
          pc_d = pc_q + PC_ONE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  assign pc_en  = (pc_d != pc_q);
  assign cnt_en = (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      pc_q  <= '0;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (pc_en)  pc_q  <= pc_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign pc_o   = pc_q;
  assign busy_o = (st_q != ST_IDLE);
endmodule

// File: rtl/xs_agen.sv
module xs_agen #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          first_i,
  input  logic          next_i,
  input  logic [AW-1:0] src_base_i,
  input  logic [AW-1:0] dst_base_i,
  input  logic [AW-1:0] stride_i,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o
);
  logic [AW-1:0] src_q, dst_q, stp_q, wa_q;
  logic          wv_q;
  logic [AW-1:0] cur_dst, cur_stp;
  logic          step;

  assign step      = first_i | next_i;
  assign rd_en_o   = step;
  assign rd_addr_o = first_i ? src_base_i : src_q;
  assign cur_dst   = first_i ? dst_base_i : dst_q;
  assign cur_stp   = first_i ? stride_i   : stp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      stp_q <= '0;
      wa_q  <= '0;
      wv_q  <= 1'b0;
    end else begin
      wv_q <= step;
      if (step) begin
        src_q <= rd_addr_o + cur_stp;
        dst_q <= cur_dst + cur_stp;
        stp_q <= cur_stp;
        wa_q  <= cur_dst;
      end
    end
  end

  assign wr_en_o   = wv_q;
  assign wr_addr_o = wa_q;
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import xs_pkg::*;
#(
  parameter  int IMEM_DEPTH = 64,
  parameter  int DATA_W     = 32,
  localparam int PC_W       = $clog2(IMEM_DEPTH),
  localparam int AW         = IMM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic [PC_W-1:0]   imem_addr_o,
  input  logic [INSN_W-1:0] imem_data_i,
  output logic              ob_rd_en_o,
  output logic [AW-1:0]     ob_addr_o,
  input  logic [DATA_W-1:0] ob_data_i,
  output logic              ib_wr_en_o,
  output logic [AW-1:0]     ib_addr_o,
  output logic [DATA_W-1:0] ib_data_o,
  output logic              busy_o
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  insn_t         ins;
  logic [AW-1:0] rs1_val, rd_val, rs2_val;
  logic          ld_we, issue_first, issue_next, is_move;
  logic [AW-1:0] src_base, dst_base, stride, ofs;

  assign ins = insn_t'(imem_data_i);

  xs_ctrl #(.PC_W(PC_W), .CNT_W(IMM_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .start_i      (start_i),
    .op_i         (ins.op),
    .imm_i        (ins.imm),
    .pc_o         (imem_addr_o),
    .busy_o       (busy_o),
    .ld_we_o      (ld_we),
    .issue_first_o(issue_first),
    .issue_next_o (issue_next)
  );

  xs_regfile #(.W(AW), .N(NREG)) u_rf (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .we_i   (ld_we),
    .waddr_i(ins.rd),
    .wdata_i(ins.imm),
    .ra_a_i (ins.rs1),
    .ra_b_i (ins.rd),
    .ra_c_i (ins.rs2),
    .rd_a_o (rs1_val),
    .rd_b_o (rd_val),
    .rd_c_o (rs2_val)
  );

  assign is_move  = (ins.op == OP_MOVE);
  assign ofs      = is_move ? ins.imm : '0;
  assign src_base = rs1_val + ofs;
  assign dst_base = rd_val + ofs;
  assign stride   = is_move ? '0 : rs2_val;

  xs_agen #(.AW(AW)) u_agen (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .first_i   (issue_first),
    .next_i    (issue_next),
    .src_base_i(src_base),
    .dst_base_i(dst_base),
    .stride_i  (stride),
    .rd_en_o   (ob_rd_en_o),
    .rd_addr_o (ob_addr_o),
    .wr_en_o   (ib_wr_en_o),
    .wr_addr_o (ib_addr_o)
  );

  assign ib_data_o = ob_data_i;
endmodule

// File: rtl/xs_chk.sv
module xs_chk #(
  parameter int PC_W = 6
) (
  input logic            clk,
  input logic            rst_core_n,
  input logic            start_i,
  input logic            busy_o,
  input logic            ob_rd_en_o,
  input logic            ib_wr_en_o,
  input logic [PC_W-1:0] imem_addr_o
);
  assert_rd_then_wr_R11: assert property (@(posedge clk) disable iff (!rst_core_n)
    ob_rd_en_o |=> ib_wr_en_o);

  assert_no_orphan_wr_R11: assert property (@(posedge clk) disable iff (!rst_core_n)
    !ob_rd_en_o |=> !ib_wr_en_o);

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    !busy_o |-> (!ob_rd_en_o && !ib_wr_en_o));

  assert_idle_pc_hold_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!busy_o && !start_i) |=> $stable(imem_addr_o));

  assert_start_pc0_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    start_i |=> (busy_o && imem_addr_o == '0));

  assert_start_no_read_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    start_i |-> !ob_rd_en_o);
endmodule

bind xfer_seq xs_chk #(.PC_W(PC_W)) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .ob_rd_en_o (ob_rd_en_o),
  .ib_wr_en_o (ib_wr_en_o),
  .imem_addr_o(imem_addr_o)
);

// File: tb/sim_xfer_seq.sv
`timescale 1ns/1ps
module sim_xfer_seq;
  localparam int DEPTH = 64;
  localparam int DW    = 32;
  localparam int PCW   = 6;
  localparam int MAXC  = 512;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [PCW-1:0] ia;
  logic [31:0]    idata;
  logic           rde, wre, busy;
  logic [15:0]    rda, wra;
  logic [DW-1:0]  obd, wrd;

  logic [31:0]    imem [DEPTH];
  int             vecs = 0;
  int             fails = 0;

  always #2.5 clk = ~clk;

  xfer_seq #(.IMEM_DEPTH(DEPTH), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .imem_addr_o(ia), .imem_data_i(idata),
    .ob_rd_en_o(rde), .ob_addr_o(rda), .ob_data_i(obd),
    .ib_wr_en_o(wre), .ib_addr_o(wra), .ib_data_o(wrd),
    .busy_o(busy)
  );

  function automatic logic [DW-1:0] obfn(logic [15:0] a);
    return {a ^ 16'h5A3C, a + 16'h1234};
  endfunction

  function automatic logic [31:0] enc(logic [3:0] op, logic [3:0] rd, logic [3:0] s1,
                                      logic [3:0] s2, logic [15:0] imm);
    return {op, rd, s1, s2, imm};
  endfunction

  function automatic string rq(int n);
    case (n)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  10: return "R10"; default: return "R11";
    endcase
  endfunction

  assign idata = imem[ia];
  always @(posedge clk) if (rde) obd <= obfn(rda);

  // expectation tables, one slot per cycle after start
  logic          e_rd [MAXC];
  logic          e_wr [MAXC];
  logic          e_pcv[MAXC];
  logic [15:0]   e_rda[MAXC];
  logic [15:0]   e_wra[MAXC];
  logic [DW-1:0] e_wrd[MAXC];
  int            e_pc [MAXC];
  int            e_req[MAXC];
  int            halt_c;
  logic [15:0]   m_reg[16];

  task automatic model();
    int t = 0;
    int pc = 0;
    for (int i = 0; i < MAXC; i++) begin
      e_rd[i] = 0; e_wr[i] = 0; e_pcv[i] = 0; e_req[i] = 5;
      e_rda[i] = '0; e_wra[i] = '0; e_wrd[i] = '0; e_pc[i] = 0;
    end
    halt_c = 0;
    while (1) begin
      logic [31:0] w;
      logic [3:0]  op, rd, s1, s2;
      logic [15:0] imm, a, d, s;
      w = imem[pc];
      {op, rd, s1, s2, imm} = w;
      e_pcv[t] = 1; e_pc[t] = pc;
      if (t > MAXC - 80) begin halt_c = t; break; end
      case (op)
        4'b0000: begin
          if (imm == 0) begin halt_c = t; e_req[t] = 5; break; end
          for (int k = 0; k < int'(imm); k++) e_req[t+k] = 4; // R4 timed wait
          t += int'(imm);
        end
        4'b0010: begin // R3 load, R0 discard
          if (rd != 0) m_reg[rd] = imm;
          e_req[t] = 3; t += 1;
        end
        4'b1000: begin // R6 single move
          a = m_reg[s1] + imm; d = m_reg[rd] + imm;
          e_rd[t] = 1; e_rda[t] = a; e_req[t] = 6;
          e_wr[t+1] = 1; e_wra[t+1] = d; e_wrd[t+1] = obfn(a); e_req[t+1] = 6;
          t += 2;
        end
        4'b1001: begin // R7 strided burst
          a = m_reg[s1]; d = m_reg[rd]; s = m_reg[s2];
          for (int k = 0; k < int'(imm); k++) begin
            e_rd[t+k] = 1; e_rda[t+k] = a; e_req[t+k] = 7;
            e_wr[t+k+1] = 1; e_wra[t+k+1] = d; e_wrd[t+k+1] = obfn(a); e_req[t+k+1] = 7;
            a = a + s; d = d + s;
          end
          e_req[t] = 7;
          t += (imm == 0) ? 1 : int'(imm) + 1;
        end
        default: begin e_req[t] = 8; t += 1; end // R8 unknown opcode
      endcase
      pc = (pc + 1) % DEPTH;
    end
  endtask

  task automatic check_cycle(int c, int tag);
    logic eb;
    logic bad;
    eb  = (c <= halt_c);
    bad = (busy !== eb) || (rde !== e_rd[c]) || (wre !== e_wr[c]) ||
          (e_rd[c] && rda !== e_rda[c]) ||
          (e_wr[c] && (wra !== e_wra[c] || wrd !== e_wrd[c])) ||
          (e_pcv[c] && int'(ia) != e_pc[c]);
    vecs++;
    if (bad) begin
      fails++;
      $display("FAIL %s cyc=%0d act busy=%0b rd=%0b@%h wr=%0b@%h/%h pc=%0d exp busy=%0b rd=%0b@%h wr=%0b@%h/%h pc=%0d",
               rq(tag != 0 ? tag : e_req[c]), c, busy, rde, rda, wre, wra, wrd, ia,
               eb, e_rd[c], e_rda[c], e_wr[c], e_wra[c], e_wrd[c], e_pc[c]);
    end
  endtask

  // abort_at >= 0: pulse start again after that cycle (only inside a wait)
  task automatic run(int abort_at, int tag);
    int pass_tag;
    model();
    pass_tag = tag;
    for (int pass = 0; pass < 2; pass++) begin
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      #1;
      for (int c = 0; c <= halt_c + 3; c++) begin
        if (c > 0) begin @(negedge clk); #1; end
        check_cycle(c, pass_tag);
        if (pass == 0 && c == abort_at) break;
      end
      if (abort_at < 0) break;
      pass_tag = 9; // R9: restarted run must replay from address 0
    end
  endtask

  function automatic logic [31:0] rand_insn();
    int k = int'($urandom % 6);
    logic [3:0] rd  = 4'($urandom);
    logic [3:0] s1  = 4'($urandom);
    logic [3:0] s2  = 4'($urandom);
    logic [3:0] op;
    case (k)
      0: return enc(4'b0000, rd, s1, s2, 16'(1 + $urandom % 5));
      1, 2: return enc(4'b0010, rd, s1, s2, 16'($urandom));
      3: return enc(4'b1000, rd, s1, s2, 16'($urandom));
      4: return enc(4'b1001, rd, s1, s2, 16'($urandom % 6));
      default: begin
        op = 4'($urandom);
        if (op == 4'b0000 || op == 4'b0010 || op == 4'b1000 || op == 4'b1001) op = 4'hF;
        return enc(op, rd, s1, s2, 16'($urandom));
      end
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog expired act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    void'($urandom(20240611));
    for (int i = 0; i < 16; i++) m_reg[i] = '0;
    for (int i = 0; i < DEPTH; i++) imem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: quiet after reset, pc at 0
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      vecs++;
      if (busy !== 1'b0 || rde !== 1'b0 || wre !== 1'b0 || ia !== '0) begin
        fails++;
        $display("FAIL R1 act busy=%0b rd=%0b wr=%0b pc=%0d exp 0 0 0 0", busy, rde, wre, ia);
      end
    end

    // Directed: registers start zero (R1), R0 discard (R3), waits, unknown, bursts
    imem[0]  = enc(4'b1000, 4'd5, 4'd6, 4'd0, 16'd7);
    imem[1]  = enc(4'b0010, 4'd1, 4'd0, 4'd0, 16'd5);
    imem[2]  = enc(4'b0010, 4'd2, 4'd0, 4'd0, 16'd3);
    imem[3]  = enc(4'b0010, 4'd3, 4'd0, 4'd0, 16'd100);
    imem[4]  = enc(4'b0010, 4'd0, 4'd0, 4'd0, 16'd77);
    imem[5]  = enc(4'b1000, 4'd3, 4'd1, 4'd0, 16'd2);
    imem[6]  = enc(4'b1000, 4'd0, 4'd0, 4'd0, 16'd9);
    imem[7]  = enc(4'b0000, 4'd0, 4'd0, 4'd0, 16'd3);
    imem[8]  = enc(4'b0101, 4'd0, 4'd0, 4'd0, 16'd40);
    imem[9]  = enc(4'b1001, 4'd3, 4'd1, 4'd2, 16'd4);
    imem[10] = enc(4'b1001, 4'd3, 4'd1, 4'd2, 16'd0);
    imem[11] = enc(4'b1001, 4'd3, 4'd1, 4'd2, 16'd1);
    imem[12] = enc(4'b0000, 4'd0, 4'd0, 4'd0, 16'd1);
    imem[13] = enc(4'b0000, 4'd0, 4'd0, 4'd0, 16'd0);
    run(-1, 0);

    // R10: wrap of burst addresses
    imem[0] = enc(4'b0010, 4'd1, 4'd0, 4'd0, 16'hFFFE);
    imem[1] = enc(4'b0010, 4'd2, 4'd0, 4'd0, 16'd1);
    imem[2] = enc(4'b0010, 4'd4, 4'd0, 4'd0, 16'hFFFF);
    imem[3] = enc(4'b1001, 4'd4, 4'd1, 4'd2, 16'd4);
    imem[4] = enc(4'b1000, 4'd1, 4'd4, 4'd0, 16'd3);
    imem[5] = enc(4'b0000, 4'd0, 4'd0, 4'd0, 16'd0);
    run(-1, 10);

    // R9: restart while in a long wait
    imem[0] = enc(4'b0010, 4'd5, 4'd0, 4'd0, 16'd9);
    imem[1] = enc(4'b0000, 4'd0, 4'd0, 4'd0, 16'd50);
    imem[2] = enc(4'b1000, 4'd5, 4'd5, 4'd0, 16'd1);
    imem[3] = enc(4'b0000, 4'd0, 4'd0, 4'd0, 16'd0);
    run(12, 0);

    // Random programs
    for (int p = 0; p < 40; p++) begin
      int len = 3 + int'($urandom % 12);
      for (int i = 0; i < len; i++) imem[i] = rand_insn();
      imem[len] = enc(4'b0000, 4'($urandom), 4'd0, 4'd0, 16'd0);
      run(-1, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule